// File: doc/BRIEF.md
# Stereo Level Control with Soft Mute and Silence Flag

This block sets the level of a two-channel stream of signed audio samples. Each sample pair arrives with a one-cycle frame strobe. Each channel is multiplied by its own 14-bit unsigned linear gain. The product is rounded back to the sample width and saturated. When the phase control is set, the sign of both results is flipped. The block registers the results and marks them with a one-cycle valid pulse.

Level changes never jump. Each channel keeps an applied gain that moves toward its target by at most a fixed step on each frame. The target is the programmed gain, or zero while either mute source is active. The mute sources are a control bit and an external active-high pin. A separate watcher counts consecutive frames in which both channels are exactly zero. It raises a flag once that run exceeds a programmable length, 1024 frames by default.

Top module: `stereo_level_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, both outputs are 0, `out_vld` is 0 and `zero_flag` is 0. Reset also loads the applied gain of each channel with full scale, which is 16383.
- R2: A frame strobe in cycle n produces a one-cycle `out_vld` in cycle n+1. In that cycle each output equals floor((sample*g + 8192) / 16384), where g is the channel's applied gain before that frame's ramp step. The result is saturated to the signed sample range.
- R3: On each frame, the applied gain moves toward its target by RAMP_STEP (default 256). When it is within one step of the target, it lands exactly on the target. Without a frame strobe it does not change.
- R4: While `mute_bit` or `mute_pin` is 1, the target of both channels is 0. Muted outputs therefore fall to 0 within ceil(16383/RAMP_STEP) frames, and they ramp back up when both mute sources are released.
- R5: When `invert` is 1, the rounded result is negated before saturation. This holds for full-scale positive and negative inputs.
- R6: `zero_flag` rises in the cycle after the frame that completes a run of more than ZERO_FRAMES (1024) consecutive frames with both samples equal to 0. It stays high while the run continues. After exactly 1024 such frames it is still 0.
- R7: A frame in which either sample is non-zero clears `zero_flag` in the next cycle and restarts the count from zero.
- R8: The two channels use independent gains and samples. A change on one channel does not alter the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe marking a valid sample pair |
| in_left | input | DATA_W | Left sample, two's complement |
| in_right | input | DATA_W | Right sample, two's complement |
| gain_left | input | GAIN_W | Left target gain, unsigned linear |
| gain_right | input | GAIN_W | Right target gain, unsigned linear |
| mute_bit | input | 1 | Mute request from the control register |
| mute_pin | input | 1 | External mute request, active high |
| invert | input | 1 | Output polarity flip for both channels |
| out_left | output | DATA_W | Scaled left sample |
| out_right | output | DATA_W | Scaled right sample |
| out_vld | output | 1 | Pulses one cycle after each frame strobe |
| zero_flag | output | 1 | Long-silence indicator |

## Verification
A wrong applied gain shows up at the outputs on the very next frame. The bench keeps its own ramped gain for each channel and compares every scaled sample against it. A missed or doubled ramp step therefore surfaces within one frame, as do a stale mute combination or a wrong rounding offset. A wrong silence count is different: it shows only at the run boundary. The bench therefore drives exactly 1024 and 1025 silent frames, then a non-zero frame followed by a second full run, so that an off-by-one or a missing restart is caught at the boundary frame.

// File: rtl/stvol_pkg.sv
package stvol_pkg;

    localparam int CH_N = 2;

    typedef enum int {
        CH_LEFT  = 0,
        CH_RIGHT = 1
    } chan_e;

    // one ramp step of the applied gain toward its target
    function automatic int unsigned ramp_next(input int unsigned cur,
                                              input int unsigned tgt,
                                              input int unsigned step);
        if (cur > tgt)
            return (cur - tgt > step) ? cur - step : tgt;
        else if (cur < tgt)
            return (tgt - cur > step) ? cur + step : tgt;
        else
            return cur;
    endfunction

endpackage

// File: rtl/stvol_gain_ramp.sv
module stvol_gain_ramp
    import stvol_pkg::*;
#(
    parameter int GAIN_W    = 14,
    parameter int RAMP_STEP = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [GAIN_W-1:0] target,
    output logic [GAIN_W-1:0] gain_app
);
    localparam logic [GAIN_W-1:0] FULL = '1;

    always_ff @(posedge clk) begin
        if (rst)
            gain_app <= FULL;
        else if (frame_vld)
            gain_app <= GAIN_W'(ramp_next(32'(gain_app), 32'(target), RAMP_STEP));
    end

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> ((gain_app >= $past(gain_app)) ?
                       (32'(gain_app) - 32'($past(gain_app))) :
                       (32'($past(gain_app)) - 32'(gain_app))) <= RAMP_STEP);

    // R3
    ramp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> $stable(gain_app));

    // R3
    ramp_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && gain_app == target) |=> gain_app == $past(target));

endmodule

// File: rtl/stvol_scaler.sv
module stvol_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 14
) (
    input  logic signed [DATA_W-1:0] sample,
    input  logic        [GAIN_W-1:0] gain,
    input  logic                     invert,
    output logic signed [DATA_W-1:0] result
);
    localparam int PW = DATA_W + GAIN_W + 2;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GAIN_W - 1);
    localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DATA_W - 1)) - PW'(1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] s_ext, g_ext, prod, rnd, flip;

    always_comb begin
        s_ext = PW'(sample);
        g_ext = $signed({{(PW - GAIN_W){1'b0}}, gain});
        prod  = s_ext * g_ext;
        rnd   = (prod + HALF) >>> GAIN_W;
        flip  = invert ? -rnd : rnd;
        if (flip > MAXV)
            result = MAXV[DATA_W-1:0];
        else if (flip < MINV)
            result = MINV[DATA_W-1:0];
        else
            result = flip[DATA_W-1:0];
    end

    // R4
    always_comb begin
        if (gain == '0)
            gain_zero_chk: assert (result == '0);
    end

endmodule

// File: rtl/stvol_zero_watch.sv
module stvol_zero_watch #(
    parameter int DATA_W      = 24,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_vld,
    input  logic [DATA_W-1:0] smp_a,
    input  logic [DATA_W-1:0] smp_b,
    output logic              zero_flag
);
    localparam int CW = $clog2(ZERO_FRAMES + 2);
    localparam logic [CW-1:0] LIMIT = CW'(ZERO_FRAMES);

    logic [CW-1:0] run_cnt;
    logic          silent;

    assign silent = (smp_a == '0) && (smp_b == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt   <= '0;
            zero_flag <= 1'b0;
        end else if (frame_vld) begin
            if (silent) begin
                if (run_cnt <= LIMIT)
                    run_cnt <= run_cnt + CW'(1);
                zero_flag <= (run_cnt >= LIMIT);
            end else begin
                run_cnt   <= '0;
                zero_flag <= 1'b0;
            end
        end
    end

    // R7
    zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && !silent) |=> !zero_flag);

    // R6
    zero_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_flag) |-> $past(frame_vld && silent));

endmodule

// File: rtl/stereo_level_ctrl.sv
module stereo_level_ctrl
    import stvol_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int GAIN_W      = 14,
    parameter int RAMP_STEP   = 256,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_vld,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic        [GAIN_W-1:0] gain_left,
    input  logic        [GAIN_W-1:0] gain_right,
    input  logic                     mute_bit,
    input  logic                     mute_pin,
    input  logic                     invert,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right,
    output logic                     out_vld,
    output logic                     zero_flag
);
    logic                     mute_any;
    logic signed [DATA_W-1:0] smp_in  [CH_N];
    logic        [GAIN_W-1:0] gain_in [CH_N];
    logic        [GAIN_W-1:0] tgt     [CH_N];
    logic        [GAIN_W-1:0] g_app   [CH_N];
    logic signed [DATA_W-1:0] scaled  [CH_N];
    logic signed [DATA_W-1:0] out_q   [CH_N];

    assign mute_any          = mute_bit | mute_pin;
    assign smp_in[CH_LEFT]   = in_left;
    assign smp_in[CH_RIGHT]  = in_right;
    assign gain_in[CH_LEFT]  = gain_left;
    assign gain_in[CH_RIGHT] = gain_right;

    for (genvar c = 0; c < CH_N; c++) begin : g_chan
        assign tgt[c] = mute_any ? '0 : gain_in[c];

        stvol_gain_ramp #(
            .GAIN_W    (GAIN_W),
            .RAMP_STEP (RAMP_STEP)
        ) u_ramp (
            .clk       (clk),
            .rst       (rst),
            .frame_vld (frame_vld),
            .target    (tgt[c]),
            .gain_app  (g_app[c])
        );

        stvol_scaler #(
            .DATA_W (DATA_W),
            .GAIN_W (GAIN_W)
        ) u_scale (
            .sample (smp_in[c]),
            .gain   (g_app[c]),
            .invert (invert),
            .result (scaled[c])
        );

        always_ff @(posedge clk) begin
            if (rst)
                out_q[c] <= '0;
            else if (frame_vld)
                out_q[c] <= scaled[c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_vld <= 1'b0;
        else
            out_vld <= frame_vld;
    end

    assign out_left  = out_q[CH_LEFT];
    assign out_right = out_q[CH_RIGHT];

    stvol_zero_watch #(
        .DATA_W      (DATA_W),
        .ZERO_FRAMES (ZERO_FRAMES)
    ) u_zero (
        .clk       (clk),
        .rst       (rst),
        .frame_vld (frame_vld),
        .smp_a     (in_left),
        .smp_b     (in_right),
        .zero_flag (zero_flag)
    );

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld |=> out_vld);

    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_vld |=> !out_vld);

    // R4
    mute_silence_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld && mute_any && g_app[CH_LEFT] == '0 && g_app[CH_RIGHT] == '0)
        |=> (out_left == '0 && out_right == '0));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_vld && !zero_flag && out_left == '0 && out_right == '0));

endmodule

// File: tb/sim_stereo_level_ctrl.sv
module sim_stereo_level_ctrl;
    localparam int DW   = 24;
    localparam int GW   = 14;
    localparam int STEP = 256;
    localparam int ZF   = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_vld = 1'b0;
    logic signed [DW-1:0] in_left = '0, in_right = '0;
    logic [GW-1:0] gain_left = '1, gain_right = '1;
    logic mute_bit = 1'b0, mute_pin = 1'b0, invert = 1'b0;
    logic signed [DW-1:0] out_left, out_right;
    logic out_vld, zero_flag;

    int n_chk = 0;
    int n_bad = 0;
    longint mg [2];
    int zcnt = 0;
    bit zexp = 1'b0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #2 clk = ~clk;

    stereo_level_ctrl u0 (
        .clk(clk), .rst(rst), .frame_vld(frame_vld),
        .in_left(in_left), .in_right(in_right),
        .gain_left(gain_left), .gain_right(gain_right),
        .mute_bit(mute_bit), .mute_pin(mute_pin), .invert(invert),
        .out_left(out_left), .out_right(out_right),
        .out_vld(out_vld), .zero_flag(zero_flag)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint model(input longint s, input longint g, input bit inv);
        longint r;
        r = (s * g + 8192) >>> 14;
        if (inv) r = -r;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    function automatic longint step_to(input longint cur, input longint tgt);
        if (cur > tgt) return (cur - tgt > STEP) ? cur - STEP : tgt;
        if (cur < tgt) return (tgt - cur > STEP) ? cur + STEP : tgt;
        return cur;
    endfunction

    function automatic logic signed [DW-1:0] rnd_smp();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr[DW-1:0];
    endfunction

    // one frame: drive, then compare against the bench model
    task automatic frame(input logic signed [DW-1:0] l, input logic signed [DW-1:0] r,
                         input string tag);
        bit mute;
        @(negedge clk);
        in_left = l; in_right = r; frame_vld = 1'b1;
        @(negedge clk);
        frame_vld = 1'b0;
        check({tag, " R2 vld"}, longint'(out_vld), 1);
        check({tag, " left"}, longint'(out_left), model(l, mg[0], invert));
        check({tag, " right"}, longint'(out_right), model(r, mg[1], invert));
        if (l == 0 && r == 0) begin
            if (zcnt <= ZF) zcnt++;
            zexp = (zcnt > ZF);
        end else begin
            zcnt = 0; zexp = 1'b0;
        end
        check({tag, " R6 R7 zero_flag"}, longint'(zero_flag), longint'(zexp));
        mute = mute_bit | mute_pin;
        mg[0] = step_to(mg[0], mute ? 0 : longint'(gain_left));
        mg[1] = step_to(mg[1], mute ? 0 : longint'(gain_right));
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        mg[0] = 16383; mg[1] = 16383;
        repeat (3) @(negedge clk);
        check("R1 out_left", longint'(out_left), 0);
        check("R1 out_vld", longint'(out_vld), 0);
        check("R1 zero_flag", longint'(zero_flag), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 after out_right", longint'(out_right), 0);
        check("R1 after out_vld", longint'(out_vld), 0);

        // R2: full gain over edge and random samples
        frame(24'sh7FFFFF, -24'sh800000, "R2 extremes");
        frame(24'sd1, -24'sd1, "R2 unit");
        frame(24'sd8192, -24'sd8193, "R2 rounding");
        for (int i = 0; i < 200; i++) frame(rnd_smp(), rnd_smp(), "R2 sweep");
        @(negedge clk);
        check("R2 vld idle", longint'(out_vld), 0);

        // R3/R8: independent ramps to new targets
        gain_left = 14'd1000; gain_right = 14'd12000;
        for (int i = 0; i < 80; i++) frame(rnd_smp(), rnd_smp(), "R3 R8 ramp");
        check("R3 landed left", mg[0], 1000);
        check("R3 landed right", mg[1], 12000);
        gain_right = 14'd0;
        for (int i = 0; i < 60; i++) frame(rnd_smp(), 24'sh7FFFFF, "R8 right only");
        check("R8 right zero", longint'(out_right), 0);

        // R4: mute from register bit, then from pin
        gain_left = '1; gain_right = '1;
        for (int i = 0; i < 70; i++) frame(rnd_smp(), rnd_smp(), "R3 up");
        mute_bit = 1'b1;
        for (int i = 0; i < 66; i++) frame(24'sh7FFFFF, -24'sh7FFFFF, "R4 mute bit");
        check("R4 muted left", longint'(out_left), 0);
        mute_bit = 1'b0;
        for (int i = 0; i < 66; i++) frame(rnd_smp(), rnd_smp(), "R4 release");
        mute_pin = 1'b1;
        for (int i = 0; i < 66; i++) frame(-24'sh800000, 24'sh7FFFFF, "R4 mute pin");
        check("R4 pin muted right", longint'(out_right), 0);
        mute_pin = 1'b0;
        for (int i = 0; i < 66; i++) frame(rnd_smp(), rnd_smp(), "R4 pin release");

        // R5: polarity flip
        invert = 1'b1;
        frame(-24'sh800000, 24'sh7FFFFF, "R5 fullscale");
        frame(24'sd1, -24'sd3, "R5 small");
        for (int i = 0; i < 100; i++) frame(rnd_smp(), rnd_smp(), "R5 sweep");
        invert = 1'b0;

        // R6/R7: silence run boundaries
        for (int i = 0; i < ZF; i++) frame('0, '0, "R6 run");
        check("R6 at 1024", longint'(zero_flag), 0);
        frame('0, '0, "R6 1025th");
        check("R6 raised", longint'(zero_flag), 1);
        frame('0, '0, "R6 hold");
        frame('0, 24'sd1, "R7 clear");
        check("R7 cleared", longint'(zero_flag), 0);
        for (int i = 0; i < ZF; i++) frame('0, '0, "R7 restart");
        check("R7 restart 1024", longint'(zero_flag), 0);
        frame('0, '0, "R7 restart 1025th");
        check("R7 raised again", longint'(zero_flag), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule